// File: doc/BRIEF.md
# Stepwise Charging Phase Sequencer

This block produces the switch enables that move a heavily loaded output node between ground and the supply through a ladder of intermediate tank levels. A full swing is never one jump: it is split into `STEPS` smaller steps. The output rests on one intermediate level per step, and the final step reaches the opposite rail. Each intermediate level has two parallel switches, one sized for charging and one for discharging. The sequencer enables only the one that matches the direction of travel.

A single data bit selects the rail the output should end on. When that bit differs from the rail currently held, the sequencer walks the levels in order. Each level stays enabled for a programmable dwell count, so the load can settle over several time constants. Successive enables are separated by a dead cycle with every switch open, so adjacent tank levels are never shorted together. A change of the data bit during a walk is deferred until the walk ends at a rail. A one-cycle done pulse marks arrival at the destination rail.

Top module: `step_charge_seq`

## Requirements
- R1: After reset only `gnd_en` is high, every other enable is low and `done` is low.
- R2: On a rising walk the charge enables `chg_en[i]` light one at a time in ascending order of i. Bit i drives tank level i+1. The walk ends with `sup_en`.
- R3: On a falling walk the discharge enables `dis_en[i]` light one at a time in descending order of i. The walk ends with `gnd_en`.
- R4: At most one enable is high in any cycle. Between two different enables there is exactly one cycle with all enables low.
- R5: Each level enable stays high for `dwell` cycles, and a `dwell` of 0 counts as 1. With the data bit changed before clock edge 0, the first gap is seen after edge 1. The destination rail is first seen after edge 2+(STEPS-1)(dwell+1).
- R6: A data bit equal to the rail currently held starts no walk. The rail enable stays high and `done` stays low.
- R7: A data change during a walk does not alter it. The walk completes at its rail, and the latest data value is then served with a new walk.
- R8: `done` is high for exactly one cycle: the first cycle in which the destination rail enable is high.
- R9: The supply enable is never reached except through the top tank level, and ground is never reached except through the lowest tank level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Target rail: 1 for supply, 0 for ground |
| dwell | input | DW | Cycles per level enable (0 treated as 1) |
| gnd_en | output | 1 | Ground switch enable |
| sup_en | output | 1 | Supply switch enable |
| chg_en | output | STEPS-1 | Charge switch enables of tank levels 1..STEPS-1 |
| dis_en | output | STEPS-1 | Discharge switch enables of tank levels 1..STEPS-1 |
| done | output | 1 | One-cycle pulse on arrival at the destination rail |

## Verification
The bench sweeps the dwell setting from 0 through 5 in both directions. It compares every port in every cycle of each walk against a schedule computed from the step count and dwell. A dwell that is one off, a missing or doubled dead cycle, or a reversed or wrong-polarity level shows up as a mismatch at a known cycle. Separate cases hold the data at the current rail, where a design that restarts would drop the rail enable or pulse done. A data reversal in mid-walk is also applied, where a design that turns around early would never reach the supply before heading back to ground.

// File: rtl/step_charge_seq.sv
module step_charge_seq #(
  parameter int STEPS = 4,
  parameter int DW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_in,
  input  logic [DW-1:0]    dwell,
  output logic             gnd_en,
  output logic             sup_en,
  output logic [STEPS-2:0] chg_en,
  output logic [STEPS-2:0] dis_en,
  output logic             done
);
  localparam int LW = $clog2(STEPS + 1);
  localparam logic [LW-1:0] TOP = LW'(STEPS);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_STEP} st_t;

  st_t          st;
  logic [LW-1:0] lvl;
  logic          up;
  logic          pend;
  logic [DW-1:0] cnt;

  wire           at_top = (lvl == TOP);
  wire           at_bot = (lvl == '0);
  wire [LW-1:0]  nxt    = up ? lvl + 1'b1 : lvl - 1'b1;
  wire [DW-1:0]  load   = (dwell == '0) ? '0 : dwell - 1'b1;
  wire           lit    = (st != S_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lvl  <= '0;
      up   <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      pend <= data_in;
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (pend != at_top) begin
            st <= S_GAP;
            up <= pend;
          end
        S_GAP: begin
          st   <= S_STEP;
          lvl  <= nxt;
          cnt  <= load;
          done <= (nxt == '0) || (nxt == TOP);
        end
        S_STEP:
          if (cnt != '0)              cnt <= cnt - 1'b1;
          else if (at_bot || at_top)  st  <= S_IDLE;
          else                        st  <= S_GAP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gnd_en = lit && at_bot;
  assign sup_en = lit && at_top;

  for (genvar i = 0; i < STEPS - 1; i++) begin : g_lvl
    wire here = (st == S_STEP) && (lvl == LW'(i + 1));
    assign chg_en[i] = here && up;
    assign dis_en[i] = here && !up;
  end
endmodule

module step_charge_seq_chk #(
  parameter int STEPS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnd_en,
  input logic             sup_en,
  input logic [STEPS-2:0] chg_en,
  input logic [STEPS-2:0] dis_en,
  input logic             done
);
  wire [2*STEPS-1:0] v = {gnd_en, sup_en, chg_en, dis_en};

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v));

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|v) |=> ((v == $past(v)) || (v == '0)));

  p_sup_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_en) |-> $past(chg_en[STEPS-2], 2));

  p_gnd_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnd_en) |-> $past(dis_en[0], 2));

  p_done_rail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gnd_en || sup_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind step_charge_seq step_charge_seq_chk #(.STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnd_en(gnd_en), .sup_en(sup_en),
  .chg_en(chg_en), .dis_en(dis_en), .done(done)
);

// File: tb/step_charge_seq_test.sv
module step_charge_seq_test;
  localparam int STEPS = 4;
  localparam int DW    = 4;

  logic clk = 0, rst_n = 0, data_in = 0;
  logic [DW-1:0] dwell = 1;
  logic gnd_en, sup_en, done;
  logic [STEPS-2:0] chg_en, dis_en;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  step_charge_seq #(.STEPS(STEPS), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .dwell(dwell),
    .gnd_en(gnd_en), .sup_en(sup_en), .chg_en(chg_en), .dis_en(dis_en),
    .done(done)
  );

  task automatic chk(input string req, input logic [2*STEPS:0] act, input logic [2*STEPS:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2*STEPS:0] pack(logic g, logic s, logic [STEPS-2:0] c, logic [STEPS-2:0] d, logic dn);
    return {g, s, c, d, dn};
  endfunction

  function automatic logic [2*STEPS:0] lvl_vec(int lvl, bit upw, bit gap, bit dn);
    logic [STEPS-2:0] c = '0, d = '0;
    if (gap) return '0;
    if (lvl > 0 && lvl < STEPS) begin
      if (upw) c[lvl-1] = 1'b1; else d[lvl-1] = 1'b1;
    end
    return pack(lvl == 0, lvl == STEPS, c, d, dn);
  endfunction

  task automatic walk(input bit upw, input int d);
    int de = (d == 0) ? 1 : d;
    int kdone = 2 + (STEPS - 1) * (de + 1);
    dwell   = DW'(d);
    data_in = upw;
    for (int k = 0; k <= kdone + de + 2; k++) begin
      int j, r, lvl;
      bit gap;
      @(posedge clk); @(negedge clk);
      if (k == 0) begin lvl = upw ? 0 : STEPS; gap = 0; end
      else begin
        j = (k - 1) / (de + 1) + 1;
        r = (k - 1) % (de + 1);
        if (j > STEPS) begin lvl = upw ? STEPS : 0; gap = 0; end
        else begin lvl = upw ? j : STEPS - j; gap = (r == 0); end
      end
      chk(upw ? "R2/R4/R5/R8 rise" : "R3/R4/R5/R8 fall",
          pack(gnd_en, sup_en, chg_en, dis_en, done),
          lvl_vec(lvl, upw, gap, k == kdone));
    end
  endtask

  task automatic hold_rail(input bit hi);
    data_in = hi;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R6 hold", pack(gnd_en, sup_en, chg_en, dis_en, done),
          lvl_vec(hi ? STEPS : 0, 1, 0, 0));
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", pack(gnd_en, sup_en, chg_en, dis_en, done), lvl_vec(0, 1, 0, 0));
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", pack(gnd_en, sup_en, chg_en, dis_en, done), lvl_vec(0, 1, 0, 0));
    hold_rail(0);
    for (int d = 0; d <= 5; d++) begin
      walk(1, d);
      hold_rail(1);
      walk(0, d);
      hold_rail(0);
    end
    // R7: reversal during a rising walk
    dwell = 2;
    data_in = 1;
    repeat (3) @(negedge clk);
    data_in = 0;
    begin
      int n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk("R7 rise completes", {31'd0, sup_en}, 32'd1);
      @(negedge clk);
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk("R7 fall follows", {31'd0, gnd_en}, 32'd1);
    end
    hold_rail(0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule